// File: doc/BRIEF.md
# Start-Record Trigger Qualifier

This block sits behind a Manchester decoder in a serial bus monitor and decides the cycle in which recording of a new message begins. The decoder reports a sync with its type (command or data), a strobe for each properly encoded bit, a pulse on any encoding error, and an end-of-word strobe carrying the parity result. A 2-bit mode input selects one of four start policies. Two policies wait for a complete word that is well encoded and has odd parity. The other two fire early, once a sync is followed by two clean bits, so that fragments and words with bad parity still get recorded.

The qualifier emits one start pulse per message. It then ignores further qualifying words until the message-end input re-arms it. Two sticky flags feed the recorder's block status word. One marks a recording that began on a data sync. The other marks an early start whose word did not finish valid. Both hold until the per-message clear input is pulsed.

Top module: `start_record_qualifier`

## Requirements
- R1: After reset, `start_rec`, `sync_err` and `inv_word_err` are low, and the qualifier is armed.
- R2: With `rec_mode` = 2'b00, a command-sync word fires `start_rec`. The word must be valid: exactly 17 bit strobes (16 data plus parity), no `manch_err`, and `parity_odd` high at `word_done`. `start_rec` is high for the single cycle that follows the `word_done` cycle.
- R3: With `rec_mode` = 2'b00, no start is given for data-sync words, bad parity, too few or too many bits, or any word cut by `manch_err`.
- R4: With `rec_mode` = 2'b01, any valid word fires a start, whatever its sync type. When that word had data sync, `sync_err` rises in the same cycle as `start_rec`.
- R5: With `rec_mode` = 2'b10, a command sync followed by two clean bit strobes fires `start_rec` in the cycle after the second strobe. Data-sync words never start under this mode.
- R6: With `rec_mode` = 2'b11, a sync of either type followed by two clean bit strobes fires a start. A data-sync start also sets `sync_err`.
- R7: Under the early modes (2'b1x), `inv_word_err` is set when the word that fired the start ends invalid. It ends invalid on a `manch_err`, on bad parity, on a bit count other than 17, or when a new sync arrives before `word_done`. A valid word leaves the flag low.
- R8: An early start needs two contiguous clean bits. A `manch_err` in place of the first or second bit prevents the start.
- R9: At most one `start_rec` pulse is given per message. Qualifying words are ignored until a `msg_end` pulse re-arms the qualifier. A `msg_end` in the same cycle as a firing word does not re-arm.
- R10: `sync_err` and `inv_word_err` stay set until a `flag_clr` pulse. A set condition in the same cycle as `flag_clr` wins, leaving the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_mode | input | 2 | Start policy select |
| sync_det | input | 1 | Pulse: properly encoded sync seen |
| sync_is_cmd | input | 1 | Sync type with `sync_det`: 1 command, 0 data |
| bit_valid | input | 1 | Pulse: one properly encoded bit decoded |
| manch_err | input | 1 | Pulse: encoding error in the current word |
| word_done | input | 1 | Pulse: word finished |
| parity_odd | input | 1 | With `word_done`: parity over the word is odd |
| msg_end | input | 1 | Pulse: message over, re-arm qualifier |
| flag_clr | input | 1 | Pulse: clear the sticky flags |
| start_rec | output | 1 | One-cycle start-record pulse |
| sync_err | output | 1 | Sticky: recording began on data sync |
| inv_word_err | output | 1 | Sticky: early-started word ended invalid |

## Verification
Every mode is swept against both sync types and a grid of word shapes: bit counts of 1, 2, 16, 17 and 18, an encoding error at bit 0, 1, 5 or 16 or none, and good or bad parity. The bit counts tell the complete-word policies from the early ones. An error at bit 0 or 1 against one at bit 5 or 16 separates "never reached two clean bits" from "started, then turned invalid". Parity and the 18-bit case show that only the full policies reject bad words before starting. Directed runs cover the exact pulse timing, one start per message, abandonment of a word by a fresh sync, and flag stickiness with a clear that coincides with a set.

// File: rtl/srq_pkg.sv
package srq_pkg;

  typedef enum logic [1:0] {
    REC_CMD_WORD  = 2'b00,
    REC_ANY_WORD  = 2'b01,
    REC_CMD_EARLY = 2'b10,
    REC_ANY_EARLY = 2'b11
  } rec_mode_e;

  typedef struct packed {
    logic early_hit;
    logic end_stb;
    logic ok;
    logic is_cmd;
  } word_evt_t;

endpackage

// File: rtl/srq_reset_sync.sv
module srq_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/srq_word_tracker.sv
module srq_word_tracker
  import srq_pkg::*;
#(
  parameter int DATA_BITS  = 16,
  parameter int EARLY_BITS = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_det,
  input  logic      sync_is_cmd,
  input  logic      bit_valid,
  input  logic      manch_err,
  input  logic      word_done,
  input  logic      parity_odd,
  output word_evt_t evt_o
);

  localparam int WORD_BITS = DATA_BITS + 1;
  localparam int CW        = $clog2(WORD_BITS + 2);
  localparam logic [CW-1:0] FULL_CNT  = CW'(WORD_BITS);
  localparam logic [CW-1:0] OVER_CNT  = CW'(WORD_BITS + 1);
  localparam logic [CW-1:0] EARLY_IDX = CW'(EARLY_BITS - 1);
  localparam logic [CW-1:0] EARLY_CNT = CW'(EARLY_BITS);

  logic          in_word_q, in_word_d;
  logic          cmd_q, cmd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          state_en;

  // next-state
  always_comb begin
    in_word_d = in_word_q;
    cmd_d     = cmd_q;
    cnt_d     = cnt_q;
    if (sync_det) begin
      in_word_d = 1'b1;
      cmd_d     = sync_is_cmd;
      cnt_d     = '0;
    end else if (in_word_q && (manch_err || word_done)) begin
      in_word_d = 1'b0;
    end else if (in_word_q && bit_valid && (cnt_q != OVER_CNT)) begin
      cnt_d = cnt_q + 1'b1;
    end
    state_en = sync_det | (in_word_q & (manch_err | word_done | bit_valid));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_word_q <= 1'b0;
      cmd_q     <= 1'b0;
      cnt_q     <= '0;
    end else if (state_en) begin
      in_word_q <= in_word_d;
      cmd_q     <= cmd_d;
      cnt_q     <= cnt_d;
    end
  end

  // events seen by the policy and flag logic
  always_comb begin
    evt_o.is_cmd    = cmd_q;
    evt_o.end_stb   = in_word_q & (sync_det | manch_err | word_done);
    evt_o.ok        = in_word_q & word_done & ~sync_det & ~manch_err &
                      (cnt_q == FULL_CNT) & parity_odd;
    evt_o.early_hit = in_word_q & bit_valid & ~manch_err & ~sync_det &
                      ~word_done & (cnt_q == EARLY_IDX);
  end

  assert_early_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.early_hit |=> (in_word_q && cnt_q == EARLY_CNT));

  assert_ok_ends_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.ok |=> !in_word_q);

endmodule

// File: rtl/srq_arm_policy.sv
module srq_arm_policy
  import srq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rec_mode_e mode,
  input  word_evt_t evt,
  input  logic      msg_end,
  output logic      fire_o,
  output logic      fire_early_o,
  output logic      fire_data_o
);

  logic armed_q, armed_d;
  logic sync_ok;
  logic early_sel;
  logic fire_full;
  logic fire_early;

  always_comb begin
    early_sel  = mode[1];
    sync_ok    = mode[0] | evt.is_cmd;
    fire_full  = ~early_sel & evt.ok & sync_ok;
    fire_early = early_sel & evt.early_hit & sync_ok;
    fire_o       = armed_q & (fire_full | fire_early);
    fire_early_o = armed_q & fire_early;
    fire_data_o  = fire_o & ~evt.is_cmd;
    if (fire_o) begin
      armed_d = 1'b0;
    end else if (msg_end) begin
      armed_d = 1'b1;
    end else begin
      armed_d = armed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else begin
      armed_q <= armed_d;
    end
  end

  assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  assert_cmd_modes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !mode[0]) |-> evt.is_cmd);

endmodule

// File: rtl/srq_flag_unit.sv
module srq_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic fire_early_i,
  input  logic fire_data_i,
  input  logic end_stb_i,
  input  logic ok_i,
  input  logic flag_clr,
  output logic start_o,
  output logic sync_err_o,
  output logic inv_err_o
);

  logic pend_q, pend_d, pend_en;
  logic start_q;
  logic sync_q, sync_d;
  logic inv_q, inv_d;
  logic inv_set;

  always_comb begin
    pend_en = fire_early_i | end_stb_i;
    pend_d  = fire_early_i;
    inv_set = pend_q & end_stb_i & ~ok_i;
    sync_d  = fire_data_i | (sync_q & ~flag_clr);
    inv_d   = inv_set | (inv_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      sync_q  <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      if (pend_en) begin
        pend_q <= pend_d;
      end
      start_q <= fire_i;
      sync_q  <= sync_d;
      inv_q   <= inv_d;
    end
  end

  assign start_o    = start_q;
  assign sync_err_o = sync_q;
  assign inv_err_o  = inv_q;

  assert_sync_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && !flag_clr) |=> sync_q);

  assert_inv_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_q && !flag_clr) |=> inv_q);

  assert_inv_after_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_q) |-> $past(pend_q));

endmodule

// File: rtl/start_record_qualifier.sv
module start_record_qualifier
  import srq_pkg::*;
#(
  parameter int DATA_BITS  = 16,
  parameter int EARLY_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rec_mode,
  input  logic       sync_det,
  input  logic       sync_is_cmd,
  input  logic       bit_valid,
  input  logic       manch_err,
  input  logic       word_done,
  input  logic       parity_odd,
  input  logic       msg_end,
  input  logic       flag_clr,
  output logic       start_rec,
  output logic       sync_err,
  output logic       inv_word_err
);

  logic      rst_sync_n;
  word_evt_t evt;
  logic      fire;
  logic      fire_early;
  logic      fire_data;
  rec_mode_e mode;

  assign mode = rec_mode_e'(rec_mode);

  srq_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srq_word_tracker #(
    .DATA_BITS  (DATA_BITS),
    .EARLY_BITS (EARLY_BITS)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sync_det    (sync_det),
    .sync_is_cmd (sync_is_cmd),
    .bit_valid   (bit_valid),
    .manch_err   (manch_err),
    .word_done   (word_done),
    .parity_odd  (parity_odd),
    .evt_o       (evt)
  );

  srq_arm_policy u_policy (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mode         (mode),
    .evt          (evt),
    .msg_end      (msg_end),
    .fire_o       (fire),
    .fire_early_o (fire_early),
    .fire_data_o  (fire_data)
  );

  srq_flag_unit u_flags (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .fire_i       (fire),
    .fire_early_i (fire_early),
    .fire_data_i  (fire_data),
    .end_stb_i    (evt.end_stb),
    .ok_i         (evt.ok),
    .flag_clr     (flag_clr),
    .start_o      (start_rec),
    .sync_err_o   (sync_err),
    .inv_err_o    (inv_word_err)
  );

  // per-message start tracking for the one-start check
  logic started_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      started_q <= 1'b0;
    end else if (msg_end) begin
      started_q <= 1'b0;
    end else if (start_rec) begin
      started_q <= 1'b1;
    end
  end

  assert_one_start_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_rec |-> !started_q);

  assert_sync_err_with_start_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sync_err) |-> start_rec);

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_rec |=> !start_rec);

endmodule

// File: tb/start_record_qualifier_test.sv
module start_record_qualifier_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rec_mode;
  logic       sync_det, sync_is_cmd, bit_valid, manch_err, word_done, parity_odd;
  logic       msg_end, flag_clr;
  logic       start_rec, sync_err, inv_word_err;

  int checks = 0;
  int errors = 0;
  int start_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  start_record_qualifier uut (
    .clk(clk), .rst_n(rst_n), .rec_mode(rec_mode),
    .sync_det(sync_det), .sync_is_cmd(sync_is_cmd), .bit_valid(bit_valid),
    .manch_err(manch_err), .word_done(word_done), .parity_odd(parity_odd),
    .msg_end(msg_end), .flag_clr(flag_clr),
    .start_rec(start_rec), .sync_err(sync_err), .inv_word_err(inv_word_err)
  );

  always @(negedge clk) begin
    if (start_rec) start_cnt = start_cnt + 1;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_ctl(bit me, bit fc);
    msg_end = me; flag_clr = fc;
    tick();
    msg_end = 0; flag_clr = 0;
  endtask

  task automatic send_sync(bit cmd);
    sync_det = 1; sync_is_cmd = cmd;
    tick();
    sync_det = 0; sync_is_cmd = 0;
  endtask

  task automatic send_word(bit cmd, int nbits, int err, bit par, bit clr_at_done);
    bit stopped = 0;
    send_sync(cmd);
    for (int i = 0; i < nbits; i++) begin
      if (!stopped) begin
        if (i == err) begin
          manch_err = 1; tick(); manch_err = 0;
          stopped = 1;
        end else begin
          bit_valid = 1; tick(); bit_valid = 0;
        end
      end
    end
    word_done = 1; parity_odd = par; flag_clr = clr_at_done;
    tick();
    word_done = 0; parity_odd = 0; flag_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bit_opts[5] = '{1, 2, 16, 17, 18};
    int err_opts[5] = '{-1, 0, 1, 5, 16};
    int snap;
    rst_n = 0; rec_mode = 2'b00;
    sync_det = 0; sync_is_cmd = 0; bit_valid = 0; manch_err = 0;
    word_done = 0; parity_odd = 0; msg_end = 0; flag_clr = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();

    // R1: reset state
    check("R1 start_rec", start_rec, 0);
    check("R1 sync_err", sync_err, 0);
    check("R1 inv_word_err", inv_word_err, 0);

    // R2: exact timing in mode 00
    rec_mode = 2'b00;
    send_word(1, 17, -1, 1, 0);
    check("R2 start in cycle after word_done", start_rec, 1);
    tick();
    check("R2 start one cycle wide", start_rec, 0);

    // R9: second word in same message ignored, re-armed by msg_end
    #1 snap = start_cnt;
    send_word(1, 17, -1, 1, 0);
    repeat (2) tick();
    #1 check("R9 no second start", start_cnt - snap, 0);
    pulse_ctl(1, 0);
    #1 snap = start_cnt;
    send_word(1, 17, -1, 1, 0);
    repeat (2) tick();
    #1 check("R9 start after re-arm", start_cnt - snap, 1);

    // R5: early timing, start after second clean bit
    pulse_ctl(1, 1);
    rec_mode = 2'b10;
    send_sync(1);
    bit_valid = 1; tick(); tick(); bit_valid = 0;
    check("R5 start after second bit", start_rec, 1);
    // R7: new sync abandons the started word
    bit_valid = 1; tick(); bit_valid = 0;
    send_sync(0);
    tick();
    check("R7 abandoned word flagged", inv_word_err, 1);

    // R10: stickiness and clear/set priority
    pulse_ctl(1, 1);
    check("R10 flag_clr clears inv", inv_word_err, 0);
    rec_mode = 2'b01;
    send_word(0, 17, -1, 1, 0);
    repeat (5) tick();
    check("R10 sync_err held", sync_err, 1);
    pulse_ctl(0, 1);
    check("R10 sync_err cleared", sync_err, 0);
    pulse_ctl(1, 0);
    send_word(0, 17, -1, 1, 1);
    check("R10 set wins over clear", sync_err, 1);

    // sweep
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 2; c++) begin
        for (int b = 0; b < 5; b++) begin
          for (int e = 0; e < 5; e++) begin
            for (int p = 0; p < 2; p++) begin
              int  nb   = bit_opts[b];
              int  er   = (err_opts[e] >= 0 && err_opts[e] < nb) ? err_opts[e] : -1;
              bit  early = m[1];
              bit  sync_ok = m[0] || (c == 1);
              bit  valid = (nb == 17) && (er < 0) && (p == 1);
              bit  reach2 = (nb >= 2) && (er < 0 || er >= 2);
              bit  exp_start = sync_ok && (early ? reach2 : valid);
              bit  exp_sync = exp_start && (c == 0);
              bit  exp_inv = early && exp_start && !valid;
              string tag;
              if (m == 0) tag = exp_start ? "R2" : "R3";
              else if (m == 1) tag = "R4";
              else if (!reach2) tag = "R8";
              else tag = (m == 2) ? "R5" : "R6";
              rec_mode = 2'(m);
              pulse_ctl(1, 1);
              tick();
              #1 snap = start_cnt;
              send_word(c[0], nb, err_opts[e], p[0], 0);
              repeat (2) tick();
              #1;
              check($sformatf("%s start m=%0d cmd=%0d n=%0d e=%0d p=%0d", tag, m, c, nb, err_opts[e], p),
                    start_cnt - snap, int'(exp_start));
              check($sformatf("%s sync_err m=%0d cmd=%0d n=%0d", (m[0] ? (m[1] ? "R6" : "R4") : tag), m, c, nb),
                    sync_err, int'(exp_sync));
              check($sformatf("R7 inv_word_err m=%0d cmd=%0d n=%0d e=%0d p=%0d", m, c, nb, err_opts[e], p),
                    inv_word_err, int'(exp_inv));
            end
          end
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule